// File: doc/BRIEF.md
# Command-Queue I2C Master Sequencer

This block is an I2C bus master whose transfers are set up one queued command at a time. Software pushes 11-bit command words into a transmit queue. Each word is either a byte to write or a request to read one byte. Two flag bits in the same word mark where the bus must be reframed: one forces a repeated START ahead of the byte, the other closes the transfer with a STOP after it. The engine produces START, the 7-bit address with its R/W bit, data and read bytes, acknowledge bits, repeated START and STOP on open-drain SCL and SDA outputs. Bytes read from the slave are placed in a receive queue.

Bit timing comes from an external tick pulse. Every bus bit takes four ticks: two with SCL low and two with SCL high. If the command queue drains while no STOP has been requested, the master keeps the bus by holding SCL low until another command arrives. If the slave does not acknowledge the address or a written byte, the transfer is aborted. An abort stays latched until software disables the controller and enables it again. Software reads the actual enable state from a separate output after each change of the request.

Top module: `i2c_cmd_master`

## Requirements
- R1: Command word fields: bits [7:0] hold the write byte; bit 8 = 1 requests a read and 0 a write; bit 9 = 1 issues STOP after this byte; bit 10 = 1 forces a repeated START before this byte.
- R2: A transfer starts with START, then the 7-bit target address (bits [6:0], MSB first), then the R/W bit (1 = read), then an acknowledge slot in which SDA is released.
- R3: Write bytes leave MSB first, with SDA changing only while SCL is low. The slave's acknowledge is sampled in the ninth bit.
- R4: During a read byte, SDA is released. The eight sampled bits are pushed to the receive queue, and the oldest byte is shown on rxData until rxPop. The master ACKs a read byte unless that byte carries the stop flag, in which case it NACKs it.
- R5: After a byte with the stop flag, the master issues STOP and returns to idle with SCL and SDA both released (1).
- R6: When the command queue is empty after a byte without the stop flag, the master holds SCL low with SDA released, keeps master-active set, and resumes on the same bus ownership (no new START) when the next command arrives.
- R7: A repeated START is needed when a command has bit 10 set or when its direction differs from the current transfer. With restartEn = 1 the master issues a repeated START; with restartEn = 0 it issues STOP and then a fresh START.
- R8: A NACK on the address or on a written byte raises txAbort, flushes the command queue and issues STOP. While txAbort is set, pushed commands are dropped.
- R9: enableStat follows enableReq only while the bus is not owned. While enableStat = 0, pushed commands are dropped, both queues are flushed and txAbort is cleared.
- R10: status bits: bit0 active (bus owned or commands queued), bit1 command queue not full, bit2 command queue empty, bit3 receive queue not empty, bit4 receive queue full, bit5 master active (bus owned).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enableReq | input | 1 | Enable request |
| restartEn | input | 1 | Allow repeated START between transfers |
| targetAddr | input | 7 | 7-bit slave address |
| tick | input | 1 | Quarter-bit timing pulse |
| cmdPush | input | 1 | Push cmdWord into the command queue |
| cmdWord | input | 11 | Command word |
| rxPop | input | 1 | Remove the oldest received byte |
| rxData | output | 8 | Oldest received byte |
| status | output | 6 | Queue and activity status bits |
| enableStat | output | 1 | Actual enable state |
| txAbort | output | 1 | Latched transfer abort |
| sclOut | output | 1 | SCL drive (0 pulls low, 1 releases) |
| sdaOut | output | 1 | SDA drive (0 pulls low, 1 releases) |
| sdaIn | input | 1 | Sensed SDA line level |

## Verification
The acknowledge-slot decision and the queue update share one tick, so they can fall in the same cycle. An address or data NACK must flush the command queue in the cycle that latches txAbort, while a successful acknowledge must pop the next command and load it in that cycle. The bench provokes both cases by queueing further commands behind a byte that a modelled slave refuses (wrong address, or the data value 0xEE). It then judges from the slave's byte log and the queue status that nothing after the refused byte reached the bus. Enable changes requested during a held bus, and pushes made while aborted, are judged the same way, through status and enableStat.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CMD_W  = BYTE_W + 3;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_BYTE, S_HOLD, S_STOP
  } seqState_t;

  typedef struct packed {
    logic accept;
    logic flushCmd;
    logic flushRx;
    logic loadAddr;
    logic loadData;
    logic sample;
    logic shift;
    logic rxPush;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_cmd_fifo.sv
module i2c_cmd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wrPtr, rdPtr;

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign dout  = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem[wrPtr[AW-1:0]] <= din;
  end
endmodule

// File: rtl/i2c_cmd_datapath.sv
module i2c_cmd_datapath
  import i2c_cmd_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int RX_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              cmdPush,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              rxPop,
  input  logic              sdaIn,
  output logic [2:0]        cmdFlags,
  output logic              cmdEmpty,
  output logic              cmdFull,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              txBit,
  output logic              sampled
);
  logic [CMD_W-1:0]  cmdHead;
  logic [BYTE_W-1:0] shiftReg;

  i2c_cmd_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdQ (
    .clk(clk), .rstN(rstN), .flush(st.flushCmd),
    .push(cmdPush && st.accept), .din(cmdWord),
    .pop(st.loadData), .dout(cmdHead), .empty(cmdEmpty), .full(cmdFull)
  );

  i2c_cmd_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxQ (
    .clk(clk), .rstN(rstN), .flush(st.flushRx),
    .push(st.rxPush), .din(shiftReg),
    .pop(rxPop), .dout(rxData), .empty(rxEmpty), .full(rxFull)
  );

  assign cmdFlags = cmdHead[CMD_W-1:BYTE_W];
  assign txBit    = shiftReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sampled  <= 1'b1;
    end else begin
      if (st.sample) sampled <= sdaIn;
      if (st.loadAddr)      shiftReg <= {targetAddr, cmdFlags[0]};
      else if (st.loadData) shiftReg <= cmdHead[BYTE_W-1:0];
      else if (st.shift)    shiftReg <= {shiftReg[BYTE_W-2:0], sampled};
    end
  end
endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       enableReq,
  input  logic       restartEn,
  input  logic       cmdEmpty,
  input  logic [2:0] cmdFlags,
  input  logic       txBit,
  input  logic       sampled,
  output dpStrobe_t  st,
  output logic       sclOut,
  output logic       sdaOut,
  output logic       enableStat,
  output logic       txAbort,
  output logic       busy
);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

  seqState_t  state;
  logic [1:0] phase;
  logic [3:0] bitCnt;
  logic dirRead, curRead, curStop, fromOwned, abortFlag;
  logic inBit, endBit, ackEnd, nackSeen, needRe, loadByte;

  always_comb begin
    inBit    = (state == S_ADDR) || (state == S_BYTE);
    endBit   = inBit && tick && (phase == 2'd3);
    ackEnd   = endBit && (bitCnt == ACK_SLOT);
    nackSeen = ackEnd && sampled && ((state == S_ADDR) || !curRead);
    needRe   = cmdFlags[2] || (cmdFlags[0] != dirRead);
    loadByte = (ackEnd && (state == S_ADDR) && !sampled) ||
               ((state == S_HOLD) && !cmdEmpty && !needRe);
    st.accept   = enableStat && !abortFlag;
    st.flushCmd = !enableStat || nackSeen;
    st.flushRx  = !enableStat;
    st.loadAddr = (state == S_START) && tick && (phase == 2'd3);
    st.loadData = loadByte;
    st.sample   = inBit && tick && (phase == 2'd2);
    st.shift    = endBit && (bitCnt != ACK_SLOT);
    st.rxPush   = ackEnd && (state == S_BYTE) && curRead;
  end

  always_comb begin
    sclOut = 1'b1;
    sdaOut = 1'b1;
    case (state)
      S_START: begin
        sclOut = (phase == 2'd0) ? !fromOwned : (phase != 2'd3);
        sdaOut = !phase[1];
      end
      S_ADDR: begin
        sclOut = phase[1];
        sdaOut = (bitCnt != ACK_SLOT) ? txBit : 1'b1;
      end
      S_BYTE: begin
        sclOut = phase[1];
        if (bitCnt != ACK_SLOT) sdaOut = curRead ? 1'b1 : txBit;
        else                    sdaOut = curRead ? curStop : 1'b1;
      end
      S_HOLD: sclOut = 1'b0;
      S_STOP: begin
        sclOut = (phase != 2'd0);
        sdaOut = phase[1];
      end
      default: ;
    endcase
  end

  assign txAbort = abortFlag;
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      phase      <= '0;
      bitCnt     <= '0;
      dirRead    <= 1'b0;
      curRead    <= 1'b0;
      curStop    <= 1'b0;
      fromOwned  <= 1'b0;
      abortFlag  <= 1'b0;
      enableStat <= 1'b0;
    end else begin
      if ((inBit || state == S_START || state == S_STOP) && tick) phase <= phase + 1'b1;
      case (state)
        S_IDLE: begin
          enableStat <= enableReq;
          if (!enableStat) abortFlag <= 1'b0;
          if (enableStat && !abortFlag && !cmdEmpty) begin
            state     <= S_START;
            phase     <= '0;
            fromOwned <= 1'b0;
          end
        end
        S_START: if (tick && phase == 2'd3) begin
          state   <= S_ADDR;
          bitCnt  <= '0;
          dirRead <= cmdFlags[0];
        end
        S_ADDR, S_BYTE: if (endBit) begin
          if (bitCnt != ACK_SLOT) bitCnt <= bitCnt + 1'b1;
          else begin
            bitCnt <= '0;
            if (nackSeen) begin
              abortFlag <= 1'b1;
              state     <= S_STOP;
            end else if (state == S_BYTE) begin
              state <= curStop ? S_STOP : S_HOLD;
            end
          end
        end
        S_HOLD: if (!cmdEmpty && needRe) begin
          state     <= restartEn ? S_START : S_STOP;
          phase     <= '0;
          fromOwned <= 1'b1;
        end
        S_STOP: if (tick && phase == 2'd3) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (loadByte) begin
        state   <= S_BYTE;
        phase   <= '0;
        bitCnt  <= '0;
        curRead <= cmdFlags[0];
        curStop <= cmdFlags[1];
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int RX_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enableReq,
  input  logic              restartEn,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              tick,
  input  logic              cmdPush,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              rxPop,
  output logic [BYTE_W-1:0] rxData,
  output logic [5:0]        status,
  output logic              enableStat,
  output logic              txAbort,
  output logic              sclOut,
  output logic              sdaOut,
  input  logic              sdaIn
);
  dpStrobe_t  strobes;
  logic [2:0] cmdFlags;
  logic cmdEmpty, cmdFull, rxEmpty, rxFull, txBit, sampled, busy;

  i2c_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .enableReq(enableReq),
    .restartEn(restartEn), .cmdEmpty(cmdEmpty), .cmdFlags(cmdFlags),
    .txBit(txBit), .sampled(sampled), .st(strobes), .sclOut(sclOut),
    .sdaOut(sdaOut), .enableStat(enableStat), .txAbort(txAbort), .busy(busy)
  );

  i2c_cmd_datapath #(.CMD_DEPTH(CMD_DEPTH), .RX_DEPTH(RX_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .targetAddr(targetAddr),
    .cmdPush(cmdPush), .cmdWord(cmdWord), .rxPop(rxPop), .sdaIn(sdaIn),
    .cmdFlags(cmdFlags), .cmdEmpty(cmdEmpty), .cmdFull(cmdFull),
    .rxData(rxData), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .txBit(txBit), .sampled(sampled)
  );

  assign status = {busy, rxFull, !rxEmpty, cmdEmpty, !cmdFull, busy || !cmdEmpty};
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] status,
  input logic       enableStat,
  input logic       txAbort,
  input logic [7:0] rxData,
  input logic       rxPop,
  input logic       sclOut,
  input logic       sdaOut
);
  // R5: with no bus ownership both lines are released
  a_r5_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !status[5] |-> (sclOut && sdaOut));

  // R8: while aborted the command queue is empty
  a_r8_abort_flushed: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |-> status[2]);

  // R9: enable state only moves while the bus is not owned
  a_r9_enable_when_free: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enableStat) |-> !$past(status[5]));

  // R9: disabled controller holds no commands one cycle later
  a_r9_off_empties: assert property (@(posedge clk) disable iff (!rstN)
    !enableStat |=> status[2]);

  // R4: head of receive queue is steady until popped
  a_r4_rx_steady: assert property (@(posedge clk) disable iff (!rstN)
    (enableStat && status[3] && !rxPop) |=> $stable(rxData));

  // R10: master active implies active
  a_r10_active_bits: assert property (@(posedge clk) disable iff (!rstN)
    status[5] |-> status[0]);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rstN(rstN), .status(status), .enableStat(enableStat),
  .txAbort(txAbort), .rxData(rxData), .rxPop(rxPop),
  .sclOut(sclOut), .sdaOut(sdaOut)
);

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 0, rstN = 0, enableReq = 0, restartEn = 1, tick = 0;
  logic cmdPush = 0, rxPop = 0;
  logic [6:0]  targetAddr = SLV;
  logic [10:0] cmdWord = '0;
  logic [7:0]  rxData;
  logic [5:0]  status;
  logic enableStat, txAbort, sclOut, sdaOut, sdaIn;
  logic sDrive = 1;

  int checks = 0, fails = 0, cyc = 0;
  int startCnt = 0, stopCnt = 0, wrCnt = 0, ackCnt = 0, rdIdx = 0;
  logic [7:0] wrLog [256];
  logic       ackLog [256];
  logic [7:0] lastAddr = 0;
  logic [7:0] expBytes [8];

  always #5 clk = ~clk;
  always @(negedge clk) tick <= rstN ? ~tick : 1'b0;
  assign sdaIn = sdaOut & sDrive;

  i2c_cmd_master u_dut (
    .clk(clk), .rstN(rstN), .enableReq(enableReq), .restartEn(restartEn),
    .targetAddr(targetAddr), .tick(tick), .cmdPush(cmdPush), .cmdWord(cmdWord),
    .rxPop(rxPop), .rxData(rxData), .status(status), .enableStat(enableStat),
    .txAbort(txAbort), .sclOut(sclOut), .sdaOut(sdaOut), .sdaIn(sdaIn)
  );

  // slave model
  int sMode = 0, sBit = 0;
  logic sInAck = 0, sNack = 0, mAck = 0, pScl = 1, pSda = 1, ln;
  logic [7:0] sSh = 0, sRd = 0;
  always @(negedge clk) begin
    ln = sdaOut & sDrive;
    if (sclOut && pScl && pSda && !ln) begin
      startCnt++; sMode = 1; sBit = 0; sInAck = 0; sDrive = 1;
    end else if (sclOut && pScl && !pSda && ln) begin
      stopCnt++; sMode = 0; sDrive = 1;
    end else if (sclOut && !pScl && sMode != 0) begin
      if (sInAck) mAck = ln;
      else if (sBit < 8) begin sSh = {sSh[6:0], ln}; sBit++; end
    end else if (!sclOut && pScl && sMode != 0) begin
      if (sInAck) begin
        sInAck = 0; sBit = 0;
        if (sMode == 3) begin
          ackLog[ackCnt] = mAck; ackCnt++;
          if (mAck) sMode = 0;
        end else if (sMode == 1) sMode = sNack ? 0 : (sSh[0] ? 3 : 2);
        else if (sNack) sMode = 0;
        if (sMode == 3) begin
          sRd = expRead(rdIdx); rdIdx++; sDrive = sRd[7];
        end else sDrive = 1;
      end else if (sBit == 8) begin
        sInAck = 1;
        if (sMode == 1) begin
          lastAddr = sSh; sNack = (sSh[7:1] != SLV); sDrive = sNack;
        end else if (sMode == 2) begin
          wrLog[wrCnt] = sSh; wrCnt++; sNack = (sSh == 8'hEE); sDrive = sNack;
        end else sDrive = 1;
      end else if (sMode == 3) sDrive = sRd[7-sBit];
    end
    pScl = sclOut;
    pSda = ln;
  end

  function automatic logic [7:0] expRead(int idx);
    return 8'hA0 + idx[7:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushCmd(logic [10:0] w);
    for (int i = 0; i < 5000 && !status[1]; i++) @(negedge clk);
    cmdWord = w; cmdPush = 1;
    @(negedge clk);
    cmdPush = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!status[5] && status[2]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic popRx(string req, logic [7:0] exp);
    chk({req, " rx not empty"}, status[3], 1);
    chk(req, rxData, exp);
    rxPop = 1; @(negedge clk); rxPop = 0;
  endtask

  task automatic reEnable();
    enableReq = 0; repeat (4) @(negedge clk);
    chk("R9 disabled", enableStat, 0);
    chk("R8 abort cleared by disable", txAbort, 0);
    enableReq = 1; repeat (4) @(negedge clk);
    chk("R9 re-enabled", enableStat, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  int b0, s0, p0, r0, a0, n;
  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset status", status, 6'b000110);
    chk("R5 reset lines", {sclOut, sdaOut}, 2'b11);
    chk("R9 reset enable", enableStat, 0);
    // R9 push while disabled is dropped
    pushCmd(11'h012);
    chk("R9 push dropped while off", status[2], 1);
    enableReq = 1; repeat (3) @(negedge clk);
    chk("R9 enable follows", enableStat, 1);

    // R1 R2 R3 R5 write transfer
    b0 = wrCnt; s0 = startCnt; p0 = stopCnt;
    pushCmd(11'h012); pushCmd(11'h034); pushCmd(11'h256);
    waitIdle();
    chk("R3 write count", wrCnt - b0, 3);
    chk("R3 byte0", wrLog[b0], 8'h12);
    chk("R3 byte1", wrLog[b0+1], 8'h34);
    chk("R1 byte2 data field", wrLog[b0+2], 8'h56);
    chk("R2 address byte", lastAddr, {SLV, 1'b0});
    chk("R5 one start one stop", {startCnt - s0, stopCnt - p0}, {32'd1, 32'd1});
    chk("R5 idle lines", {sclOut, sdaOut, status[5]}, 3'b110);

    // R6 hold when queue drains, R9 enable held while owned
    b0 = wrCnt; s0 = startCnt;
    pushCmd(11'h077);
    for (int i = 0; i < 3000 && wrCnt == b0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R6 hold scl low", sclOut, 0);
    chk("R6 hold sda released", sdaOut, 1);
    chk("R6 master active in hold", status[5], 1);
    enableReq = 0; repeat (10) @(negedge clk);
    chk("R9 enable kept while owned", enableStat, 1);
    pushCmd(11'h288);
    waitIdle();
    chk("R6 resumed byte", wrLog[b0+1], 8'h88);
    chk("R6 no new start", startCnt - s0, 1);
    chk("R9 enable drops when free", enableStat, 0);
    enableReq = 1; repeat (3) @(negedge clk);

    // R4 R7 write then reads with repeated start
    s0 = startCnt; p0 = stopCnt; r0 = rdIdx; a0 = ackCnt;
    pushCmd(11'h005); pushCmd(11'h500); pushCmd(11'h100); pushCmd(11'h300);
    waitIdle();
    chk("R7 repeated start count", {startCnt - s0, stopCnt - p0}, {32'd2, 32'd1});
    chk("R2 read address", lastAddr, {SLV, 1'b1});
    for (int i = 0; i < 3; i++) popRx("R4 read data", expRead(r0 + i));
    chk("R4 ack pattern", {ackLog[a0], ackLog[a0+1], ackLog[a0+2]}, 3'b001);

    // R7 restart disabled -> stop then start on direction change
    restartEn = 0;
    s0 = startCnt; p0 = stopCnt; r0 = rdIdx;
    pushCmd(11'h009); pushCmd(11'h300);
    waitIdle();
    chk("R7 stop+start when restart off", {startCnt - s0, stopCnt - p0}, {32'd2, 32'd2});
    popRx("R7 read after fresh start", expRead(r0));
    restartEn = 1;

    // R8 address NACK
    targetAddr = 7'h11;
    b0 = wrCnt; p0 = stopCnt;
    pushCmd(11'h0AB); pushCmd(11'h2CD);
    waitIdle();
    chk("R8 abort on address nack", txAbort, 1);
    chk("R8 queue flushed", status[2], 1);
    chk("R8 nothing written", wrCnt - b0, 0);
    chk("R8 stop issued", stopCnt - p0, 1);
    pushCmd(11'h0AB);
    chk("R8 push dropped while aborted", status[2], 1);
    targetAddr = SLV;
    reEnable();

    // R8 data NACK with queued followers
    b0 = wrCnt;
    pushCmd(11'h0EE); pushCmd(11'h011); pushCmd(11'h222);
    waitIdle();
    chk("R8 abort on data nack", txAbort, 1);
    chk("R8 only refused byte sent", wrCnt - b0, 1);
    chk("R8 refused byte", wrLog[b0], 8'hEE);
    chk("R5 lines released after abort", {sclOut, sdaOut}, 2'b11);
    reEnable();

    // R3 R1 random write bursts
    for (int r = 0; r < 6; r++) begin
      n = 1 + ($urandom % 6);
      b0 = wrCnt;
      for (int k = 0; k < n; k++) begin
        expBytes[k] = 8'($urandom);
        if (expBytes[k] == 8'hEE) expBytes[k] = 8'hEF;
        pushCmd({1'b0, (k == n - 1), 1'b0, expBytes[k]});
      end
      waitIdle();
      chk("R3 random count", wrCnt - b0, n);
      for (int k = 0; k < n; k++) chk("R3 random byte", wrLog[b0+k], expBytes[k]);
    end

    summary();
    $finish;
  end
endmodule